// File: doc/BRIEF.md
# Floating-Point Compare Flag and Conditional Branch Resolver

This block compares two single-precision IEEE 754 operands under a selected relation and captures the outcome in a one-bit condition flag. The flag is a register that persists. A compare strobe overwrites it on the next rising clock edge, and otherwise it keeps its value for as long as needed. The compare and the branch that uses its outcome are therefore two separate operations, possibly many cycles apart.

The branch side reads only the stored flag. When a branch is requested, the branch is taken if the flag matches the requested polarity (branch-if-set or branch-if-clear). The resolver then produces the next program counter: either the fall-through address PC + 4 or the target PC + 4 + (sign-extended 16-bit offset × 4). All address arithmetic wraps modulo 2^32.

Top module: `fpcc_top`

## Requirements
- R1: The condition flag reads 0 while reset is asserted and after reset until the first compare strobe is seen.
- R2: With relation code 2'b01 (less-than), a compare sets the flag to 1 exactly when A is strictly less than B, and clears it otherwise.
- R3: With relation code 2'b00 (equal), a compare sets the flag exactly when A equals B. Positive and negative zero count as equal.
- R4: With relation code 2'b10 (less-or-equal), a compare sets the flag exactly when A is less than or equal to B.
- R5: Ordering follows sign-magnitude rules: every negative value is below every positive value, and between two negatives the one with the larger magnitude is the smaller. Infinities and subnormals are ordered like any other value.
- R6: If either operand is a NaN (exponent all ones with a nonzero fraction), every relation yields 0 and the flag is cleared.
- R7: Relation code 2'b11 is reserved. A compare with it clears the flag.
- R8: The flag changes only on the rising edge that samples `cmp_valid` high. With the strobe low it holds its value regardless of the operands or relation code.
- R9: With `br_valid` high, `br_taken` is 1 when `br_if_set` is 1 and the flag is 1, or when `br_if_set` is 0 and the flag is 0. In every other case it is 0.
- R10: When taken, `next_pc` = `pc` + 4 + (sign-extended `br_offset` shifted left by 2), modulo 2^32. For example, an offset of 25 gives pc+104.
- R11: With `br_valid` low, or with the branch not taken, `br_taken` is 0 and `next_pc` is `pc` + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe; the flag is loaded on this edge |
| cmp_rel | input | 2 | Relation code: 00 equal, 01 less-than, 10 less-or-equal, 11 reserved |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| br_valid | input | 1 | Branch request |
| br_if_set | input | 1 | 1: branch when flag set; 0: branch when flag clear |
| pc | input | 32 | Address of the branch |
| br_offset | input | 16 | Signed word offset |
| cond_flag | output | 1 | Stored condition flag |
| br_taken | output | 1 | Branch is taken |
| next_pc | output | 32 | Fall-through or target address |

## Verification
A wrong flag value shows at `cond_flag` one edge after the compare strobe. It shows again as an inverted `br_taken` and a wrong `next_pc` for every branch issued before the next compare, so a defect in the relation logic cannot stay hidden. A flag that leaks on cycles without a strobe shows up as a change while the operands are swept during idle cycles. A wrong offset extension shows only for negative offsets, so those offsets and a wrapping PC are driven along with the positive examples.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  typedef enum logic [1:0] {
    REL_EQ   = 2'b00,
    REL_LT   = 2'b01,
    REL_LE   = 2'b10,
    REL_RSVD = 2'b11
  } rel_e;

endpackage

// File: rtl/fpcc_rst_sync.sv
module fpcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [MAG_W-1:0]  mag,
  output logic              is_nan,
  output logic              is_zero
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;

  always_comb begin
    sign    = word[WORD_W-1];
    exp_f   = word[MAG_W-1:FRAC_W];
    frac_f  = word[FRAC_W-1:0];
    mag     = word[MAG_W-1:0];
    exp_max = &exp_f;
    is_nan  = exp_max && (frac_f != '0);
    is_zero = (mag == '0);
  end

endmodule

// File: rtl/fpcc_relation.sv
module fpcc_relation
  import fpcc_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  rel_e             rel,
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             nan_a,
  input  logic             zero_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             nan_b,
  input  logic             zero_b,
  output logic             result
);

  logic unordered;
  logic both_zero;
  logic mag_lt;
  logic mag_gt;
  logic is_eq;
  logic is_lt;

  always_comb begin
    unordered = nan_a | nan_b;
    both_zero = zero_a & zero_b;
    mag_lt    = (mag_a < mag_b);
    mag_gt    = (mag_a > mag_b);

    is_eq = both_zero || ((sign_a == sign_b) && (mag_a == mag_b));

    if (both_zero) begin
      is_lt = 1'b0;
    end else if (sign_a != sign_b) begin
      is_lt = sign_a;
    end else if (sign_a) begin
      is_lt = mag_gt;
    end else begin
      is_lt = mag_lt;
    end

    result = 1'b0;
    if (!unordered) begin
      unique case (rel)
        REL_EQ:   result = is_eq;
        REL_LT:   result = is_lt;
        REL_LE:   result = is_lt | is_eq;
        default:  result = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fpcc_flag_reg.sv
module fpcc_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic load_val,
  output logic flag
);

  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (load_en) begin
      flag_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/fpcc_branch.sv
module fpcc_branch #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int INSN_BYTES = 4,
  localparam int EXT_W = PC_W - OFF_W,
  localparam int SHIFT = $clog2(INSN_BYTES)
) (
  input  logic             flag,
  input  logic             req,
  input  logic             if_set,
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic             taken,
  output logic [PC_W-1:0]  next_pc
);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] target;

  always_comb begin
    seq_pc  = pc + PC_W'(INSN_BYTES);
    off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    target  = seq_pc + (off_ext << SHIFT);
    taken   = req && (flag == if_set);
    next_pc = taken ? target : seq_pc;
  end

endmodule

// File: rtl/fpcc_top.sv
module fpcc_top
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int PC_W   = 32,
  parameter int OFF_W  = 16,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W,
  localparam int N_OPS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_rel,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              br_valid,
  input  logic              br_if_set,
  input  logic [PC_W-1:0]   pc,
  input  logic [OFF_W-1:0]  br_offset,
  output logic              cond_flag,
  output logic              br_taken,
  output logic [PC_W-1:0]   next_pc
);

  logic              rst_sync_n;
  logic [N_OPS-1:0]  op_sign;
  logic [N_OPS-1:0]  op_nan;
  logic [N_OPS-1:0]  op_zero;
  logic [MAG_W-1:0]  op_mag [N_OPS];
  logic              rel_result;
  rel_e              rel_sel;

  fpcc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    logic [WORD_W-1:0] word_sel;
    assign word_sel = (g == 0) ? op_a : op_b;
    fpcc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word    (word_sel),
      .sign    (op_sign[g]),
      .mag     (op_mag[g]),
      .is_nan  (op_nan[g]),
      .is_zero (op_zero[g])
    );
  end

  assign rel_sel = rel_e'(cmp_rel);

  fpcc_relation #(.MAG_W(MAG_W)) u_rel (
    .rel    (rel_sel),
    .sign_a (op_sign[0]),
    .mag_a  (op_mag[0]),
    .nan_a  (op_nan[0]),
    .zero_a (op_zero[0]),
    .sign_b (op_sign[1]),
    .mag_b  (op_mag[1]),
    .nan_b  (op_nan[1]),
    .zero_b (op_zero[1]),
    .result (rel_result)
  );

  fpcc_flag_reg u_flag (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (cmp_valid),
    .load_val (rel_result),
    .flag     (cond_flag)
  );

  fpcc_branch #(.PC_W(PC_W), .OFF_W(OFF_W), .INSN_BYTES(4)) u_br (
    .flag    (cond_flag),
    .req     (br_valid),
    .if_set  (br_if_set),
    .pc      (pc),
    .offset  (br_offset),
    .taken   (br_taken),
    .next_pc (next_pc)
  );

endmodule

// File: rtl/fpcc_checker.sv
module fpcc_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int PC_W   = 32,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              cmp_valid,
  input logic [1:0]        cmp_rel,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic              br_valid,
  input logic              br_if_set,
  input logic [PC_W-1:0]   pc,
  input logic              cond_flag,
  input logic              br_taken,
  input logic [PC_W-1:0]   next_pc
);

  logic a_nan;
  logic b_nan;
  assign a_nan = (&op_a[WORD_W-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
  assign b_nan = (&op_b[WORD_W-2:FRAC_W]) && (|op_b[FRAC_W-1:0]);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !cmp_valid |=> $stable(cond_flag)); // R8

  AST_NAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmp_valid && (a_nan || b_nan)) |=> !cond_flag); // R6

  AST_RSVD_CLEARS: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmp_valid && cmp_rel == 2'b11) |=> !cond_flag); // R7

  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmp_valid && cmp_rel == 2'b00 && op_a == op_b && !a_nan) |=> cond_flag); // R3

  AST_LT_SELF: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmp_valid && cmp_rel == 2'b01 && op_a == op_b) |=> !cond_flag); // R2

  AST_TAKEN_POLARITY: assert property (@(posedge clk) disable iff (!rst_ok)
    br_taken |-> (br_valid && cond_flag == br_if_set)); // R9

  AST_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_ok)
    !br_taken |-> next_pc == pc + PC_W'(4)); // R11

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_ok) |-> !cond_flag); // R1

endmodule

bind fpcc_top fpcc_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cmp_valid (cmp_valid),
  .cmp_rel   (cmp_rel),
  .op_a      (op_a),
  .op_b      (op_b),
  .br_valid  (br_valid),
  .br_if_set (br_if_set),
  .pc        (pc),
  .cond_flag (cond_flag),
  .br_taken  (br_taken),
  .next_pc   (next_pc)
);

// File: tb/fpcc_top_tb.sv
module fpcc_top_tb;

  logic        clk;
  logic        rst_n;
  logic        cmp_valid;
  logic [1:0]  cmp_rel;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        br_valid;
  logic        br_if_set;
  logic [31:0] pc;
  logic [15:0] br_offset;
  logic        cond_flag;
  logic        br_taken;
  logic [31:0] next_pc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fpcc_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_rel   (cmp_rel),
    .op_a      (op_a),
    .op_b      (op_b),
    .br_valid  (br_valid),
    .br_if_set (br_if_set),
    .pc        (pc),
    .br_offset (br_offset),
    .cond_flag (cond_flag),
    .br_taken  (br_taken),
    .next_pc   (next_pc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sample_val(input int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h8000_0000;
      2:  return 32'h3f80_0000;
      3:  return 32'hbf80_0000;
      4:  return 32'h4000_0000;
      5:  return 32'hc000_0000;
      6:  return 32'h7f80_0000;
      7:  return 32'hff80_0000;
      8:  return 32'h7fc0_0000;
      9:  return 32'hffc0_0001;
      10: return 32'h0000_0001;
      11: return 32'h8000_0001;
      12: return 32'h7f7f_ffff;
      13: return 32'hff7f_ffff;
      14: return 32'h3f80_0001;
      default: return 32'h3f7f_ffff;
    endcase
  endfunction

  function automatic bit is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  function automatic longint order_key(input logic [31:0] x);
    longint m;
    m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic bit expect_flag(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rel);
    longint ka;
    longint kb;
    if (is_nan(a) || is_nan(b)) return 1'b0;
    ka = order_key(a);
    kb = order_key(b);
    case (rel)
      2'b00:   return ka == kb;
      2'b01:   return ka < kb;
      2'b10:   return ka <= kb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_cmp(input logic [31:0] a, input logic [31:0] b, input logic [1:0] rel);
    @(negedge clk);
    op_a = a; op_b = b; cmp_rel = rel; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic chk_branch(input logic [31:0] p, input logic [15:0] off, input bit req, input bit if_set);
    bit          exp_taken;
    logic [31:0] exp_pc;
    @(negedge clk);
    pc = p; br_offset = off; br_valid = req; br_if_set = if_set;
    #1;
    exp_taken = req && (cond_flag == if_set);
    exp_pc = exp_taken ? (p + 32'd4 + 32'(int'($signed(off)) * 4)) : (p + 32'd4);
    if (req) chk(br_taken == exp_taken, "R9 taken", {31'b0, br_taken}, {31'b0, exp_taken});
    else     chk(br_taken == 1'b0, "R11 idle taken", {31'b0, br_taken}, 32'd0);
    if (exp_taken) chk(next_pc == exp_pc, "R10 target", next_pc, exp_pc);
    else           chk(next_pc == exp_pc, "R11 fall-through", next_pc, exp_pc);
    br_valid = 1'b0;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] a;
    logic [31:0] b;
    bit          e;
    bit          held;
    rst_n = 1'b0; cmp_valid = 1'b0; cmp_rel = 2'b00; op_a = '0; op_b = '0;
    br_valid = 1'b0; br_if_set = 1'b0; pc = '0; br_offset = '0;
    repeat (3) @(negedge clk);
    chk(cond_flag == 1'b0, "R1 in reset", {31'b0, cond_flag}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cond_flag == 1'b0, "R1 after reset", {31'b0, cond_flag}, 32'd0);

    // R2 R3 R4 R5 R6 R7: sweep all pairs under all relation codes
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          a = sample_val(i);
          b = sample_val(j);
          do_cmp(a, b, 2'(r));
          e = expect_flag(a, b, 2'(r));
          if (is_nan(a) || is_nan(b))
            chk(cond_flag == e, "R6 nan", {31'b0, cond_flag}, {31'b0, e});
          else if (r == 3)
            chk(cond_flag == e, "R7 reserved", {31'b0, cond_flag}, {31'b0, e});
          else if (r == 0)
            chk(cond_flag == e, "R3 equal", {31'b0, cond_flag}, {31'b0, e});
          else if (r == 1)
            chk(cond_flag == e, "R2 less-than R5", {31'b0, cond_flag}, {31'b0, e});
          else
            chk(cond_flag == e, "R4 less-or-equal R5", {31'b0, cond_flag}, {31'b0, e});
        end
      end
    end

    // R8: flag holds while operands change without strobe
    for (int f = 0; f < 2; f++) begin
      do_cmp(32'h3f80_0000, (f == 1) ? 32'h4000_0000 : 32'h3f80_0000, 2'b01);
      held = cond_flag;
      chk(held == f[0], "R8 setup", {31'b0, held}, {31'b0, f[0]});
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        op_a = sample_val(k); op_b = sample_val(15 - k); cmp_rel = 2'(k);
      end
      @(negedge clk);
      chk(cond_flag == held, "R8 hold", {31'b0, cond_flag}, {31'b0, held});
    end

    // R9 R10 R11: branches read the stored flag
    for (int f = 0; f < 2; f++) begin
      do_cmp(32'hc000_0000, 32'h3f80_0000, (f == 1) ? 2'b01 : 2'b00);
      for (int t = 0; t < 2; t++) begin
        chk_branch(32'h0000_1000, 16'd25,    1'b1, t[0]);
        chk_branch(32'h0000_1000, 16'd100,   1'b1, t[0]);
        chk_branch(32'h0000_1000, 16'hffff,  1'b1, t[0]);
        chk_branch(32'h0004_0000, 16'h8000,  1'b1, t[0]);
        chk_branch(32'hffff_fffc, 16'h0001,  1'b1, t[0]);
        chk_branch(32'h0000_2000, 16'h7fff,  1'b1, t[0]);
        chk_branch(32'h0000_1000, 16'd25,    1'b0, t[0]);
        chk_branch(32'hffff_fffc, 16'd3,     1'b0, t[0]);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule